// File: doc/BRIEF.md
# Hiccup-Protected PWM Switching Regulator Controller

This block is the digital core of a fixed-frequency switching DC regulator. A frame tick, derived elsewhere from the inverter's countdown chain, marks the start of each switching period of nominally 4.8 kHz. Within each period the switch is enabled for a number of clock cycles set by an 8-bit duty command. The duty command stands in for the output of an external error amplifier. Only the duty cycle changes; the period is fixed by the tick.

Three per-phase overcurrent flags come from external comparators, each set when its phase draws more than 150% of rated load. A raised flag ends the current pulse at once and starts a timed inhibit interval. Switching then stays off for a whole number of switching periods. Afterwards it restarts cleanly at a period boundary. If the overload is still present, the block re-enters inhibit and keeps cycling between inhibit and run for as long as the fault lasts. An inhibit status output and a saturating event counter report this hiccup activity.

Top module: `pwm_hiccup_reg`

## Requirements
- R1: Synchronous active-high reset clears `sw_en`, `inhibit` and `hiccup_count` to 0. After reset, `sw_en` stays low until the first `frame_tick` has been sampled.
- R2: A `frame_tick` sampled high at a clock edge starts a new period. Counting the first cycle after that edge as position 0, and with no fault or inhibit, `sw_en` is high exactly while the position is below `duty_cmd`. The position saturates at 255 when a period is longer than 256 cycles.
- R3: A `duty_cmd` of 0 keeps `sw_en` low for the whole period. A `duty_cmd` of 255 in a 256-cycle period gives 255 high cycles.
- R4: Any single bit of `phase_oc` held high forces `sw_en` low after the second rising clock edge that samples it. Bits 0, 1 and 2 each map to one output phase and are treated alike.
- R5: One edge after the synchronized fault appears, `inhibit` rises and `hiccup_count` increments. `inhibit` falls at the edge that samples the INHIBIT_PERIODS-th `frame_tick` after entry.
- R6: Overcurrent flags raised during inhibit neither lengthen it nor change `hiccup_count`.
- R7: The edge that ends inhibit is a frame boundary. With a non-zero duty and no fault, `sw_en` is high in the cycle right after that edge.
- R8: If the fault persists through a restart, `sw_en` stays low, inhibit re-enters one edge after it ended, and `hiccup_count` increments again.
- R9: `hiccup_count` saturates at its all-ones value and holds there on further hiccups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse starting each switching period |
| duty_cmd | input | DUTY_W (8) | On-time in clock cycles per period |
| phase_oc | input | NUM_PHASES (3) | Asynchronous per-phase overcurrent flags |
| sw_en | output | 1 | Power switch enable |
| inhibit | output | 1 | High while the hiccup inhibit interval runs |
| hiccup_count | output | CNT_W (8) | Saturating count of inhibit entries |

## Verification
The bench builds the block with INHIBIT_PERIODS = 3 and CNT_W = 2. A full inhibit therefore spans only a few frames, and the event counter reaches its ceiling of 3 after three hiccups. This makes both release timing and counter saturation reachable in a short run. Frame spacing is varied between 150 and 301 cycles, which exercises ramp saturation in long periods as well as duties above the period length. Random duty changes and short fault bursts are compared cycle by cycle against a bench model.

// File: rtl/pwm_hiccup_pkg.sv
package pwm_hiccup_pkg;

    // Controller operating state
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } reg_state_e;

    // Per-cycle events seen by the hiccup controller
    typedef struct packed {
        logic fault;
        logic tick;
    } ctrl_evt_t;

    // Width needed to count from 0 up to and including n
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/oc_sync.sv
module oc_sync #(
    parameter int unsigned NUM_PHASES = 3,
    parameter int unsigned STAGES     = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PHASES-1:0] oc_raw,
    output logic                  fault_any
);
    logic [NUM_PHASES-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= oc_raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign fault_any = |chain[STAGES-1];

endmodule

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
    parameter int unsigned DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_tick,
    input  logic [DUTY_W-1:0] duty_cmd,
    output logic              pwm_on
);
    localparam logic [DUTY_W-1:0] RAMP_TOP = '1;

    logic [DUTY_W-1:0] ramp;

    always_ff @(posedge clk) begin
        if (rst)                   ramp <= RAMP_TOP;
        else if (frame_tick)       ramp <= '0;
        else if (ramp != RAMP_TOP) ramp <= ramp + 1'b1;
    end

    assign pwm_on = (ramp < duty_cmd);

    // R2
    ramp_restart_chk: assert property (@(posedge clk) disable iff (rst)
        frame_tick |=> (ramp == '0));

    // R3
    duty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (duty_cmd == '0) |-> !pwm_on);

endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl
    import pwm_hiccup_pkg::*;
#(
    parameter int unsigned INHIBIT_PERIODS = 48,
    parameter int unsigned CNT_W           = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_tick,
    input  logic             fault_any,
    output logic             inhibit,
    output logic [CNT_W-1:0] hiccup_count
);
    localparam int unsigned       PW      = cnt_width(INHIBIT_PERIODS);
    localparam logic [PW-1:0]     LAST_P  = PW'(INHIBIT_PERIODS - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;

    reg_state_e       state;
    logic [PW-1:0]    periods_seen;
    ctrl_evt_t        evt;

    assign evt.fault = fault_any;
    assign evt.tick  = frame_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_RUN;
            periods_seen <= '0;
            hiccup_count <= '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (evt.fault) begin
                        state        <= ST_HOLD;
                        periods_seen <= '0;
                        if (hiccup_count != CNT_MAX)
                            hiccup_count <= hiccup_count + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (evt.tick) begin
                        if (periods_seen == LAST_P) begin
                            state        <= ST_RUN;
                            periods_seen <= '0;
                        end else begin
                            periods_seen <= periods_seen + 1'b1;
                        end
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assign inhibit = (state == ST_HOLD);

    // R5
    hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!inhibit && fault_any) |=> inhibit);

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(inhibit) |-> ((hiccup_count == $past(hiccup_count) + 1'b1) ||
                            ($past(hiccup_count) == CNT_MAX)));

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (inhibit && !frame_tick) |=> (inhibit && $stable(hiccup_count)));

    // R7
    release_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(inhibit) |-> $past(frame_tick));

    // R9
    count_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (hiccup_count == CNT_MAX) |=> (hiccup_count == CNT_MAX));

endmodule

// File: rtl/pwm_hiccup_reg.sv
module pwm_hiccup_reg #(
    parameter int unsigned DUTY_W          = 8,
    parameter int unsigned NUM_PHASES      = 3,
    parameter int unsigned SYNC_STAGES     = 2,
    parameter int unsigned INHIBIT_PERIODS = 48,
    parameter int unsigned CNT_W           = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_tick,
    input  logic [DUTY_W-1:0]     duty_cmd,
    input  logic [NUM_PHASES-1:0] phase_oc,
    output logic                  sw_en,
    output logic                  inhibit,
    output logic [CNT_W-1:0]      hiccup_count
);
    logic fault_any;
    logic pwm_on;

    oc_sync #(
        .NUM_PHASES (NUM_PHASES),
        .STAGES     (SYNC_STAGES)
    ) i_sync (
        .clk       (clk),
        .rst       (rst),
        .oc_raw    (phase_oc),
        .fault_any (fault_any)
    );

    pwm_ramp #(
        .DUTY_W (DUTY_W)
    ) i_ramp (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .duty_cmd   (duty_cmd),
        .pwm_on     (pwm_on)
    );

    hiccup_ctrl #(
        .INHIBIT_PERIODS (INHIBIT_PERIODS),
        .CNT_W           (CNT_W)
    ) i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .frame_tick   (frame_tick),
        .fault_any    (fault_any),
        .inhibit      (inhibit),
        .hiccup_count (hiccup_count)
    );

    assign sw_en = pwm_on & ~inhibit & ~fault_any;

    // R4
    fault_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (!inhibit && fault_any) |=> !sw_en);

endmodule

// File: tb/test_pwm_hiccup_reg.sv
module test_pwm_hiccup_reg;
    localparam int N_INH  = 3;
    localparam int CW     = 2;
    localparam int CMAX   = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_tick = 1'b0;
    logic [7:0] duty_cmd = '0;
    logic [2:0] phase_oc = '0;
    logic       sw_en;
    logic       inhibit;
    logic [CW-1:0] hiccup_count;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwm_hiccup_reg #(
        .DUTY_W(8), .NUM_PHASES(3), .SYNC_STAGES(2),
        .INHIBIT_PERIODS(N_INH), .CNT_W(CW)
    ) i_pwm_hiccup_reg (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .duty_cmd(duty_cmd),
        .phase_oc(phase_oc), .sw_en(sw_en), .inhibit(inhibit),
        .hiccup_count(hiccup_count)
    );

    // Bench reference model, expressed in terms of the requirements
    logic [2:0] m_seen1, m_seen2;
    int m_age, m_left, m_cnt;
    bit m_hold;

    always @(posedge clk) begin
        if (rst) begin
            m_seen1 <= '0; m_seen2 <= '0; m_age <= 255;
            m_hold <= 0; m_left <= 0; m_cnt <= 0;
        end else begin
            m_seen1 <= phase_oc;
            m_seen2 <= m_seen1;
            m_age   <= frame_tick ? 0 : ((m_age >= 255) ? 255 : m_age + 1);
            if (!m_hold) begin
                if (m_seen2 != 0) begin
                    m_hold <= 1; m_left <= N_INH;
                    m_cnt  <= (m_cnt >= CMAX) ? CMAX : m_cnt + 1;
                end
            end else if (frame_tick) begin
                if (m_left == 1) m_hold <= 0;
                m_left <= m_left - 1;
            end
        end
    end

    function automatic bit exp_sw(bit hold, logic [2:0] seen, int age, int duty);
        return !hold && (seen == 0) && (age < duty);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    int gap_lo = 255, gap_hi = 255, gap_left = 10;
    bit last_tick;
    int hi_acc = 0, prev_highs = -1;

    task automatic step();
        @(negedge clk);
        last_tick = frame_tick;
        chk(sw_en === exp_sw(m_hold, m_seen2, m_age, duty_cmd), "R2", "sw_en model",
            sw_en, exp_sw(m_hold, m_seen2, m_age, duty_cmd));
        chk(inhibit === m_hold, "R5", "inhibit model", inhibit, m_hold);
        chk(hiccup_count == m_cnt, "R9", "count model", hiccup_count, m_cnt);
        if (last_tick) begin prev_highs = hi_acc; hi_acc = 0; end
        hi_acc += sw_en;
        if (gap_left == 0) begin
            frame_tick = 1'b1;
            gap_left = gap_lo + int'($urandom_range(gap_hi - gap_lo));
        end else begin
            frame_tick = 1'b0;
            gap_left--;
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic to_frame_start();
        do step(); while (!last_tick);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int ticks;
        int cnt_before;
        void'($urandom(32'd2024));
        run(4);
        rst = 1'b0;
        step();
        // R1 reset state and no pulse before first tick
        chk(sw_en == 0, "R1", "sw_en after reset", sw_en, 0);
        chk(inhibit == 0, "R1", "inhibit after reset", inhibit, 0);
        chk(hiccup_count == 0, "R1", "count after reset", hiccup_count, 0);
        duty_cmd = 8'd200;
        run(5);
        chk(sw_en == 0, "R1", "sw_en before first tick", sw_en, 0);

        // R3 duty extremes, R2 intermediate duty and short period
        duty_cmd = 8'd0;   run(600);
        chk(prev_highs == 0, "R3", "highs at duty 0", prev_highs, 0);
        duty_cmd = 8'd255; run(600);
        chk(prev_highs == 255, "R3", "highs at duty 255", prev_highs, 255);
        duty_cmd = 8'd100; run(600);
        chk(prev_highs == 100, "R2", "highs at duty 100", prev_highs, 100);
        gap_lo = 149; gap_hi = 149; duty_cmd = 8'd200; run(500);
        chk(prev_highs == 150, "R2", "highs duty above period", prev_highs, 150);
        gap_lo = 255; gap_hi = 255;

        // R4/R5/R6/R7 for phases 0 and 1
        for (int k = 0; k < 2; k++) begin
            duty_cmd = 8'd255;
            to_frame_start();
            run(5);
            chk(sw_en == 1, "R4", "pulse running", sw_en, 1);
            phase_oc[k] = 1'b1;
            step(); step();
            chk(sw_en == 0, "R4", "pulse cut", sw_en, 0);
            chk(inhibit == 0, "R5", "inhibit not yet", inhibit, 0);
            step();
            chk(inhibit == 1, "R5", "inhibit entered", inhibit, 1);
            chk(hiccup_count == k + 1, "R5", "count step", hiccup_count, k + 1);
            phase_oc = '0;
            cnt_before = hiccup_count;
            ticks = 0;
            for (int i = 0; i < 60; i++) begin
                phase_oc = 3'($urandom_range(7));
                step();
                if (last_tick) ticks++;
            end
            phase_oc = '0;
            do begin step(); if (last_tick) ticks++; end while (inhibit);
            chk(ticks == N_INH, "R5", "inhibit length in ticks", ticks, N_INH);
            chk(hiccup_count == cnt_before, "R6", "count unchanged in inhibit",
                hiccup_count, cnt_before);
            chk(last_tick == 1, "R7", "release on tick", last_tick, 1);
            chk(sw_en == 1, "R7", "pulse on restart", sw_en, 1);
        end

        // R8 persistent fault on phase 2, R9 saturation
        phase_oc[2] = 1'b1;
        run(3);
        chk(hiccup_count == 3, "R4", "phase 2 trips", hiccup_count, 3);
        do step(); while (inhibit);
        chk(sw_en == 0, "R8", "no pulse under fault", sw_en, 0);
        step();
        chk(inhibit == 1, "R8", "re-entry", inhibit, 1);
        do step(); while (inhibit);
        step();
        chk(inhibit == 1, "R8", "second re-entry", inhibit, 1);
        chk(hiccup_count == CMAX, "R9", "count saturated", hiccup_count, CMAX);
        phase_oc = '0;
        do step(); while (inhibit);

        // Random mix
        gap_lo = 150; gap_hi = 300;
        begin
            int burst = 0;
            for (int i = 0; i < 30000; i++) begin
                if ($urandom_range(199) == 0) duty_cmd = 8'($urandom_range(255));
                if (burst > 0) begin
                    burst--;
                    if (burst == 0) phase_oc = '0;
                end else if ($urandom_range(2999) == 0) begin
                    phase_oc = 3'(1 << $urandom_range(2));
                    burst = 1 + int'($urandom_range(4));
                end
                step();
            end
        end
        finish_run();
    end
endmodule